// File: doc/BRIEF.md
# Multi-format stereo serial audio receiver

This block deserialises a stereo PCM stream carried on three wires: a bit clock, a frame clock and a single data line. It runs entirely on the bit clock. Every bit of data and the frame clock level are taken on the rising bit clock edge. Each complete channel word is handed out as a 24-bit, MSB-aligned sample, together with a tag saying whether it is the left or the right channel. The sample is held behind a valid/ready pair until the consumer takes it.

A control word selects one of four framing conventions and one of three word lengths. The four framings are: a one-bit-delayed convention (I2S), left-justified, right-justified, and a pulse-framed mode (DSP). In the pulse-framed mode, a single frame pulse starts both channel words back to back. The receiver never counts a fixed number of bit clocks per slot. It works only from frame clock transitions and from the selected word length, so it accepts bursty or short slots.

The receiver is built around one state machine. Its states are:

- ST_ARM: the first cycle after reset, which only captures the frame clock level.
- ST_WAIT: waiting for a slot start.
- ST_DELAY: the one-bit gap before the MSB.
- ST_SHIFT: collecting word bits.
- ST_RJ_FILL: shifting continuously in right-justified mode until the next frame transition.

Its transitions are:

- ARM→WAIT: always.
- Any state except ARM → DELAY, SHIFT or RJ_FILL: on a slot start, as the mode dictates.
- DELAY→SHIFT: on the next bit.
- SHIFT→WAIT: when the word is complete.
- SHIFT→SHIFT: when the word is complete in pulse-framed mode after the left word, where the state stays in ST_SHIFT with the channel switched to right.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is asserted and after its release, out_valid is low. The first bit clock after reset only records the frame clock level, and no sample is produced until a slot start has been seen.
- R2: ctrl_word[5:4] selects the framing: 00 I2S, 01 right-justified, 10 DSP (pulse-framed), 11 left-justified. ctrl_word[9:8] selects the word length: 00 = 24, 01 = 20, 10 = 16, 11 = 24. All other control bits are ignored. An all-zero control word therefore means I2S with 24-bit words.
- R3: In I2S mode, any change of the frame clock starts a slot. The MSB is the bit taken one bit clock after the change. A slot with the frame clock low is left, and a slot with it high is right.
- R4: In left-justified mode, any change of the frame clock starts a slot and the bit taken at the change is the MSB. A slot with the frame clock high is left.
- R5: In right-justified mode, at each frame clock change the word is the last N bits taken before that change, where N is the selected length. The word is tagged by the level that is ending, with high meaning left. The slot before the first change after reset is not emitted.
- R6: In DSP mode, only a rising frame clock starts a frame, and a falling edge is ignored. The left word's MSB is taken one bit clock after the rise. The right word's MSB follows the left word's LSB directly. Channel tags come from this order only.
- R7: A word shorter than 24 bits is output in the top bits of out_data, with zeros in the bits below it.
- R8: Bits after a completed word and before the next slot start are ignored. A slot just long enough for the word (I2S N+1, left-justified or right-justified N) is received correctly.
- R9: out_valid rises after the rising edge that completes a word. For right-justified mode, that is the edge that sees the frame clock change. While out_ready is low, out_valid, out_data and out_right hold. An accepted sample clears out_valid on the next edge unless a new word completes there.
- R10: A word that completes while an earlier one is still pending replaces it. If an accept and a new word fall on the same edge, out_valid stays high with the new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Active-low reset, synchronous to bclk |
| frame_in | input | 1 | Frame clock (channel level, or frame pulse in DSP mode) |
| data_in | input | 1 | Serial data, MSB first |
| ctrl_word | input | CTRL_W (16) | Control word; bits 5:4 framing, bits 9:8 word length |
| out_ready | input | 1 | Consumer accepts the pending sample |
| out_valid | output | 1 | A sample is pending |
| out_data | output | SAMPLE_W (24) | MSB-aligned sample |
| out_right | output | 1 | 1 = right channel, 0 = left |

## Verification
The output register can be asked to give up a pending sample and to take a new word on the same bit clock edge. This happens when out_ready is first raised exactly on the edge where the next word completes. The bench holds out_ready low through the left slot of an I2S frame, then raises it on the bit that carries the right word's LSB. It expects two handshakes in order: the left word first, then the right word, with no drop of out_valid in between. A separate run keeps out_ready low for the whole frame and expects only the right word to remain pending.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_RJ  = 2'b01,
        FMT_DSP = 2'b10,
        FMT_LJ  = 2'b11
    } rx_fmt_e;

    typedef enum logic [2:0] {
        ST_ARM,
        ST_WAIT,
        ST_DELAY,
        ST_SHIFT,
        ST_RJ_FILL
    } rx_state_e;

    // Word length in bits for a length code; code 3 falls back to full width.
    function automatic int unsigned word_len(input logic [1:0] code,
                                             input int unsigned full);
        int unsigned len;
        if (code == 2'b11) len = full;
        else               len = full - 4 * int'(code);
        return len;
    endfunction

endpackage

// File: rtl/pcm_rx_frame_edge.sv
module pcm_rx_frame_edge (
    input  logic bclk,
    input  logic rst_n,
    input  logic frame_in,
    output logic frame_prev,
    output logic any_edge,
    output logic rise_edge
);

    always_ff @(posedge bclk) begin
        if (!rst_n) frame_prev <= 1'b0;
        else        frame_prev <= frame_in;
    end

    always_comb begin
        any_edge  = frame_in ^ frame_prev;
        rise_edge = frame_in & ~frame_prev;
    end

endmodule

// File: rtl/pcm_rx_slot_fsm.sv
module pcm_rx_slot_fsm
    import pcm_rx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    localparam int CNT_W   = $clog2(SAMPLE_W + 1)
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  rx_fmt_e             fmt,
    input  logic [1:0]          len_code,
    input  logic                frame_in,
    input  logic                frame_prev,
    input  logic                any_edge,
    input  logic                rise_edge,
    input  logic                data_in,
    output logic                emit,
    output logic [SAMPLE_W-1:0] emit_data,
    output logic                emit_right
);

    rx_state_e           st_q, st_n;
    logic [CNT_W-1:0]    cnt_q, cnt_n;
    logic [SAMPLE_W-1:0] sh_q, sh_n;
    logic [SAMPLE_W-1:0] hist_q, hist_n;
    logic                ch_q, ch_n;
    logic [CNT_W-1:0]    n_bits;
    logic [CNT_W-1:0]    cnt_inc;
    logic                slot_start;
    logic [SAMPLE_W-1:0] raw_word;

    assign n_bits     = CNT_W'(word_len(len_code, SAMPLE_W));
    assign cnt_inc    = cnt_q + CNT_W'(1);
    assign slot_start = (fmt == FMT_DSP) ? rise_edge : any_edge;

    // State register
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            st_q   <= ST_ARM;
            cnt_q  <= '0;
            sh_q   <= '0;
            hist_q <= '0;
            ch_q   <= 1'b0;
        end else begin
            st_q   <= st_n;
            cnt_q  <= cnt_n;
            sh_q   <= sh_n;
            hist_q <= hist_n;
            ch_q   <= ch_n;
        end
    end

    // Next state and word outputs
    always_comb begin
        st_n       = st_q;
        cnt_n      = cnt_q;
        sh_n       = sh_q;
        ch_n       = ch_q;
        hist_n     = {hist_q[SAMPLE_W-2:0], data_in};
        emit       = 1'b0;
        emit_right = ch_q;
        raw_word   = '0;
        unique case (st_q)
            ST_ARM: st_n = ST_WAIT;
            ST_WAIT, ST_DELAY, ST_SHIFT, ST_RJ_FILL: begin
                if (slot_start) begin
                    unique case (fmt)
                        FMT_RJ: begin
                            if (st_q == ST_RJ_FILL) begin
                                emit       = 1'b1;
                                raw_word   = hist_q;
                                emit_right = ~frame_prev;
                            end
                            st_n = ST_RJ_FILL;
                        end
                        FMT_LJ: begin
                            sh_n  = {{(SAMPLE_W-1){1'b0}}, data_in};
                            cnt_n = CNT_W'(1);
                            ch_n  = ~frame_in;
                            st_n  = ST_SHIFT;
                        end
                        FMT_I2S: begin
                            ch_n = frame_in;
                            st_n = ST_DELAY;
                        end
                        FMT_DSP: begin
                            ch_n = 1'b0;
                            st_n = ST_DELAY;
                        end
                    endcase
                end else if (st_q == ST_DELAY) begin
                    sh_n  = {{(SAMPLE_W-1){1'b0}}, data_in};
                    cnt_n = CNT_W'(1);
                    st_n  = ST_SHIFT;
                end else if (st_q == ST_SHIFT) begin
                    sh_n  = {sh_q[SAMPLE_W-2:0], data_in};
                    cnt_n = cnt_inc;
                    if (cnt_inc == n_bits) begin
                        emit       = 1'b1;
                        raw_word   = sh_n;
                        emit_right = ch_q;
                        if (fmt == FMT_DSP && !ch_q) begin
                            ch_n  = 1'b1;
                            cnt_n = '0;
                        end else begin
                            st_n = ST_WAIT;
                        end
                    end
                end
            end
            default: st_n = ST_WAIT;
        endcase
        emit_data = raw_word << (CNT_W'(SAMPLE_W) - n_bits);
    end

    // R1: nothing leaves the block in the arming cycle
    p_arm_quiet_r1: assert property (@(posedge bclk) disable iff (!rst_n)
        (st_q == ST_ARM) |-> !emit);

    // R5: right-justified words only ever leave on a frame clock change
    p_rj_on_edge_r5: assert property (@(posedge bclk) disable iff (!rst_n)
        (emit && fmt == FMT_RJ) |-> any_edge);

    // R6: after the left word in pulse mode, the right word is collected next
    p_dsp_order_r6: assert property (@(posedge bclk) disable iff (!rst_n)
        (emit && fmt == FMT_DSP && !emit_right && !rise_edge)
            |=> (st_q == ST_SHIFT && ch_q));

    // R8: the bit count never passes the selected word length
    p_count_bound_r8: assert property (@(posedge bclk) disable iff (!rst_n)
        (st_q == ST_SHIFT) |-> (cnt_q <= n_bits));

endmodule

// File: rtl/pcm_rx_out_stage.sv
module pcm_rx_out_stage #(
    parameter int SAMPLE_W = 24
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] load_data,
    input  logic                load_right,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data,
    output logic                out_right
);

    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_right <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
            out_right <= load_right;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R9: a pending sample stays put until it is taken
    p_hold_r9: assert property (@(posedge bclk) disable iff (!rst_n)
        (out_valid && !out_ready && !load)
            |=> (out_valid && $stable(out_data) && $stable(out_right)));

    // R9: an accepted sample is gone on the next edge if nothing replaces it
    p_release_r9: assert property (@(posedge bclk) disable iff (!rst_n)
        (out_valid && out_ready && !load) |=> !out_valid);

    // R10: a new word always leaves a sample pending
    p_load_pending_r10: assert property (@(posedge bclk) disable iff (!rst_n)
        load |=> out_valid);

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
    import pcm_rx_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int CTRL_W    = 16,
    parameter int FMT_LSB   = 4,
    parameter int LEN_LSB   = 8
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                frame_in,
    input  logic                data_in,
    input  logic [CTRL_W-1:0]   ctrl_word,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data,
    output logic                out_right
);

    rx_fmt_e             fmt;
    logic [1:0]          len_code;
    logic                frame_prev;
    logic                any_edge;
    logic                rise_edge;
    logic                emit;
    logic [SAMPLE_W-1:0] emit_data;
    logic                emit_right;
    logic                ctrl_unused;

    assign fmt         = rx_fmt_e'(ctrl_word[FMT_LSB +: 2]);
    assign len_code    = ctrl_word[LEN_LSB +: 2];
    assign ctrl_unused = ^ctrl_word;

    pcm_rx_frame_edge u_edge (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .frame_in   (frame_in),
        .frame_prev (frame_prev),
        .any_edge   (any_edge),
        .rise_edge  (rise_edge)
    );

    pcm_rx_slot_fsm #(.SAMPLE_W(SAMPLE_W)) u_fsm (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .fmt        (fmt),
        .len_code   (len_code),
        .frame_in   (frame_in),
        .frame_prev (frame_prev),
        .any_edge   (any_edge),
        .rise_edge  (rise_edge),
        .data_in    (data_in),
        .emit       (emit),
        .emit_data  (emit_data),
        .emit_right (emit_right)
    );

    pcm_rx_out_stage #(.SAMPLE_W(SAMPLE_W)) u_out (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .load       (emit),
        .load_data  (emit_data),
        .load_right (emit_right),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_right  (out_right)
    );

    // R7: a 16-bit word leaves with its low byte cleared
    p_low_zero_r7: assert property (@(posedge bclk) disable iff (!rst_n)
        (emit && len_code == 2'b10) |=> (out_data[7:0] == 8'h00));

endmodule

// File: tb/pcm_serial_rx_bench.sv
module pcm_serial_rx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 11;

    // {junk, fmt[1:0], len[1:0], slot[5:0], pulse[1:0], left[23:0], right[23:0]}
    localparam logic [60:0] VEC [NVEC] = '{
        {1'b0, 2'b00, 2'b00, 6'd32, 2'd0, 24'hA53C81, 24'h123456},
        {1'b0, 2'b00, 2'b01, 6'd25, 2'd0, 24'h800001, 24'h7FFFFF},
        {1'b1, 2'b00, 2'b10, 6'd32, 2'd0, 24'hC0FFEE, 24'h0F0F0F},
        {1'b0, 2'b11, 2'b00, 6'd24, 2'd0, 24'h5AA55A, 24'hFEDCBA},
        {1'b0, 2'b11, 2'b10, 6'd32, 2'd0, 24'h8001FF, 24'h7FFE00},
        {1'b0, 2'b01, 2'b00, 6'd32, 2'd0, 24'h13579B, 24'hECA864},
        {1'b0, 2'b01, 2'b01, 6'd20, 2'd0, 24'hFFFFF0, 24'h00001F},
        {1'b0, 2'b01, 2'b10, 6'd32, 2'd0, 24'hBEEF77, 24'h4321AA},
        {1'b0, 2'b10, 2'b00, 6'd32, 2'd1, 24'h9ABCDE, 24'h654321},
        {1'b0, 2'b10, 2'b01, 6'd32, 2'd3, 24'hF00F0F, 24'h0FF0F0},
        {1'b0, 2'b00, 2'b11, 6'd32, 2'd0, 24'h876543, 24'h2468AC}
    };

    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_in = 1'b0;
    logic        data_in = 1'b0;
    logic [15:0] ctrl_word = 16'h0000;
    logic        out_ready = 1'b1;
    logic        out_valid;
    logic [23:0] out_data;
    logic        out_right;

    int n_checks = 0;
    int n_fails  = 0;
    int rec_cnt  = 0;
    logic [23:0] rec_data  [8];
    logic        rec_right [8];

    always #(CLK_PERIOD/2) bclk = ~bclk;

    pcm_serial_rx u_pcm_serial_rx (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .frame_in  (frame_in),
        .data_in   (data_in),
        .ctrl_word (ctrl_word),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_right (out_right)
    );

    // Handshake monitor: values seen here hold through the next rising edge
    always @(negedge bclk) begin
        #1;
        if (rst_n && out_valid && out_ready) begin
            if (rec_cnt < 8) begin
                rec_data[rec_cnt]  = out_data;
                rec_right[rec_cnt] = out_right;
            end
            rec_cnt = rec_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int len_of(input logic [1:0] code);
        case (code)
            2'b01:   return 20;
            2'b10:   return 16;
            default: return 24;
        endcase
    endfunction

    function automatic logic [23:0] aligned(input logic [23:0] v, input int n);
        return v & (24'hFFFFFF << (24 - n));
    endfunction

    function automatic logic word_bit(input logic [23:0] v, input int n, input int k);
        logic [23:0] w;
        w = v >> (24 - n);
        return w[n - 1 - k];
    endfunction

    task automatic drive_bit(input logic lvl, input logic b);
        @(negedge bclk);
        frame_in = lvl;
        data_in  = b;
    endtask

    function automatic logic idle_level(input logic [1:0] fmt);
        return (fmt == 2'b00) ? 1'b1 : 1'b0;
    endfunction

    task automatic restart(input logic [1:0] fmt, input logic [1:0] len,
                           input bit junk, input logic rdy);
        @(negedge bclk);
        rst_n     = 1'b0;
        out_ready = rdy;
        frame_in  = idle_level(fmt);
        data_in   = 1'b0;
        ctrl_word = (junk ? 16'hFCCF : 16'h0000) | (16'(fmt) << 4) | (16'(len) << 8);
        repeat (3) @(negedge bclk);
        rst_n   = 1'b1;
        rec_cnt = 0;
        drive_bit(idle_level(fmt), 1'b0);
        drive_bit(idle_level(fmt), 1'b0);
    endtask

    // One stereo frame; rdy_idx >= 0 raises out_ready at that bit of the right slot
    task automatic send_frame(input logic [1:0] fmt, input int n, input int slot,
                              input int pw, input logic [23:0] l, input logic [23:0] r,
                              input int rdy_idx);
        if (fmt == 2'b10) begin
            for (int i = 0; i < 2 * slot; i++) begin
                logic b;
                b = 1'b0;
                if (i >= 1 && i <= n)           b = word_bit(l, n, i - 1);
                else if (i > n && i <= 2 * n)   b = word_bit(r, n, i - n - 1);
                drive_bit(i < pw, b);
            end
            for (int i = 0; i < 4; i++) drive_bit(1'b0, 1'b0);
        end else begin
            logic left_lvl;
            left_lvl = (fmt == 2'b00) ? 1'b0 : 1'b1;
            for (int ch = 0; ch < 2; ch++) begin
                for (int i = 0; i < slot; i++) begin
                    int k;
                    logic b;
                    k = -1;
                    if (fmt == 2'b00 && i >= 1 && i <= n) k = i - 1;
                    if (fmt == 2'b11 && i < n)            k = i;
                    if (fmt == 2'b01 && i >= slot - n)    k = i - (slot - n);
                    b = (k < 0) ? 1'b0 : word_bit(ch == 0 ? l : r, n, k);
                    drive_bit(ch == 0 ? left_lvl : ~left_lvl, b);
                    if (ch == 1 && i == rdy_idx) out_ready = 1'b1;
                end
            end
            for (int i = 0; i < 4; i++) drive_bit(left_lvl, 1'b0);
        end
        repeat (2) @(negedge bclk);
        #2;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1: reset state and the arming cycle
        repeat (2) @(negedge bclk);
        #1;
        check(out_valid == 1'b0, "R1 valid during reset", 32'(out_valid), 32'h0);
        restart(2'b00, 2'b00, 1'b0, 1'b1);
        #1;
        check(out_valid == 1'b0, "R1 valid after reset", 32'(out_valid), 32'h0);
        check(rec_cnt == 0, "R1 no sample before slot", 32'(rec_cnt), 32'h0);

        // Table walk: R2..R8 over every framing and length
        for (int v = 0; v < NVEC; v++) begin
            logic [60:0] e;
            logic [1:0]  fmt;
            int          n;
            string       tag;
            e   = VEC[v];
            fmt = e[59:58];
            n   = len_of(e[57:56]);
            case (fmt)
                2'b00:   tag = "R3 i2s";
                2'b01:   tag = "R5 rj";
                2'b10:   tag = "R6 dsp";
                default: tag = "R4 lj";
            endcase
            restart(fmt, e[57:56], e[60], 1'b1);
            send_frame(fmt, n, int'(e[55:50]), int'(e[49:48]), e[47:24], e[23:0], -1);
            check(rec_cnt == 2, $sformatf("%s R2 R8 sample count vec%0d", tag, v),
                  32'(rec_cnt), 32'd2);
            check(rec_data[0] == aligned(e[47:24], n) && rec_right[0] == 1'b0,
                  $sformatf("%s R7 left word vec%0d", tag, v),
                  {7'h0, rec_right[0], rec_data[0]}, {8'h0, aligned(e[47:24], n)});
            check(rec_data[1] == aligned(e[23:0], n) && rec_right[1] == 1'b1,
                  $sformatf("%s R7 right word vec%0d", tag, v),
                  {7'h0, rec_right[1], rec_data[1]}, {8'h1, aligned(e[23:0], n)});
        end

        // R9 R10: consumer stalls for the whole frame, newer word replaces older
        restart(2'b00, 2'b00, 1'b0, 1'b0);
        send_frame(2'b00, 24, 32, 0, 24'h31415F, 24'h271828, -1);
        check(out_valid == 1'b1, "R9 valid held while stalled", 32'(out_valid), 32'h1);
        check(out_data == 24'h271828 && out_right == 1'b1, "R10 pending replaced by right",
              {7'h0, out_right, out_data}, {8'h1, 24'h271828});
        check(rec_cnt == 0, "R9 no handshake while stalled", 32'(rec_cnt), 32'h0);
        @(negedge bclk);
        out_ready = 1'b1;
        repeat (2) @(negedge bclk);
        #2;
        check(rec_cnt == 1 && rec_data[0] == 24'h271828, "R9 single accept of held word",
              32'(rec_cnt), 32'h1);
        check(out_valid == 1'b0, "R9 valid drops after accept", 32'(out_valid), 32'h0);

        // R10: accept of the left word and load of the right word on one edge
        restart(2'b00, 2'b10, 1'b0, 1'b0);
        send_frame(2'b00, 16, 32, 0, 24'hABCD00, 24'h5A5A00, 16);
        check(rec_cnt == 2, "R10 both words survive same-edge accept",
              32'(rec_cnt), 32'h2);
        check(rec_data[0] == 24'hABCD00 && rec_right[0] == 1'b0, "R10 first is left",
              {7'h0, rec_right[0], rec_data[0]}, {8'h0, 24'hABCD00});
        check(rec_data[1] == 24'h5A5A00 && rec_right[1] == 1'b1, "R10 second is right",
              {7'h0, rec_right[1], rec_data[1]}, {8'h1, 24'h5A5A00});

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule